// File: doc/BRIEF.md
# Dual-Rail Avionics Word Receiver

This block turns a digitized bipolar return-to-zero line into 32-bit words. The line arrives as two level inputs, one that is high while a "one" is on the line and one that is high while a "zero" is on the line. Both low is null. Both inputs are synchronous to `clk`. An internal tick divides the master clock to give ten line samples per bit time. A framer measures the length of every data phase and every null phase, shifts the bits into a register and raises an end-of-word event after the 32nd valid bit. A storage stage can screen each word against two programmed compare bits. It replaces the last bit with a parity-error flag and holds the word in a latch.

The host reads the latch as two 16-bit halves. It presents a half-select and strobes the read enable for one cycle. The read data is combinational from the latch and the select. An active-low ready flag shows that a word is waiting, and it stays low until both halves have been taken, in either order. The flag is a plain level and not a valid/ready stream. The line cannot be stalled, so there is no back-pressure: a word that is accepted before the host finishes reading replaces the latched word.

The receiver recovers from faults by itself. A sample with both rails high, or a phase with the wrong length, discards the word in progress. The framer then waits for a null stretch of three bit times before it arms again. It also starts in that waiting state after reset.

Top module: `avio_word_rx`

## Requirements
- R1: One line sample is taken every `DIV_FAST` clocks when `slow_rate`=0 and every `DIV_SLOW` clocks when `slow_rate`=1. A bit is nominally 5 samples of data and 5 samples of null, so a word sent at the other rate is never accepted.
- R2: The first bit on the line lands in latch bit 0 and the k-th bit lands in latch bit k-1. `rd_hi`=0 returns latch bits [15:0] and `rd_hi`=1 returns latch bits [31:16].
- R3: When the data phase of the 32nd valid bit ends, the word is accepted and `ready_n` goes low. A gap of 30 null samples before bit 32 drops the partial word.
- R4: With `filt_en`=1, a word is accepted only if its line bits 9 and 10 (latch bits 8 and 9) equal `filt_bits[0]` and `filt_bits[1]`. With `filt_en`=0, every complete word is accepted.
- R5: Latch bit 31 reads 0 when the 32 received bits hold an odd number of ones, and 1 otherwise. Latch bits 30..0 are the received bits.
- R6: `ready_n` returns high only after both halves have been read, in either order. Reading the same half twice does not release it. A read strobe while `ready_n` is high has no effect.
- R7: A word accepted while `ready_n` is low overwrites the latch and requires both halves to be read again.
- R8: A sample with both rails high aborts the word in progress. After a null stretch of at least 30 samples, the next word is accepted.
- R9: Reset drives `ready_n` high and stops any word in progress. Line activity that resumes in the middle of a word is not accepted.
- R10: A data phase shorter than 3 or longer than 7 samples, or a null phase between bits outside that range, aborts the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_rate | input | 1 | Selects the sample divider: 0 for fast, 1 for slow |
| filt_en | input | 1 | Enables screening of words on line bits 9 and 10 |
| filt_bits | input | 2 | Compare values: [0] for line bit 9, [1] for line bit 10 |
| line_one | input | 1 | High while a "one" is on the line |
| line_zero | input | 1 | High while a "zero" is on the line |
| rd_en | input | 1 | One-cycle strobe that marks the selected half as read |
| rd_hi | input | 1 | Half-select: 0 for bits [15:0], 1 for bits [31:16] |
| rd_data | output | 16 | Selected half of the latched word |
| ready_n | output | 1 | Low while an accepted word has not been fully read |

## Verification
The framer and store are driven with all-zero, all-one and alternating words, walking single ones and an arithmetic sequence. These show bit order and the half mapping, and they give both parity outcomes. All four combinations of bits 9 and 10 are sent against a fixed compare value, which separates matching words from rejected ones. Words are also sent at the wrong rate, with both rails high, or with a shortened data phase. Each of these must leave `ready_n` high, and a clean word that follows must still be received. This shows that the framer aborts and then re-arms correctly. Reads in both orders, a repeated read of the same half, back-to-back words without a read, and a reset in the middle of a word exercise the ready-flag rules.

// File: rtl/avw_pkg.sv
package avw_pkg;
  typedef enum logic [1:0] {
    FR_GAPW  = 2'd0,
    FR_IDLE  = 2'd1,
    FR_MARK  = 2'd2,
    FR_SPACE = 2'd3
  } fr_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/avw_tick.sv
module avw_tick #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick
);
  localparam int DMAX = avw_pkg::imax(DIV_FAST, DIV_SLOW);
  localparam int CW   = $clog2(DMAX);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  generate
    if (DIV_FAST == DIV_SLOW) begin : g_one_rate
      assign lim = CW'(DIV_FAST - 1);
    end else begin : g_two_rate
      assign lim = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/avw_framer.sv
module avw_framer #(
  parameter int OSR = 10,
  parameter int WB  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line_one,
  input  logic          line_zero,
  output logic          eos,
  output logic [WB-1:0] word
);
  import avw_pkg::*;

  localparam int PH_NOM = OSR / 2;
  localparam int PH_TOL = OSR / 5;
  localparam int PMIN   = PH_NOM - PH_TOL;
  localparam int PMAX   = PH_NOM + PH_TOL;
  localparam int GAP    = 3 * OSR;
  localparam int RW     = $clog2(GAP + 1);
  localparam int CW     = $clog2(WB);
  localparam logic [RW-1:0] RMAX = RW'(PMAX + 1);

  fr_state_t     st;
  logic [RW-1:0] run;
  logic [CW-1:0] cnt;
  logic          val;
  logic [WB-1:0] sr;
  logic          nul, bad, in_ph;

  assign nul   = !line_one && !line_zero;
  assign bad   = line_one && line_zero;
  assign in_ph = (run >= RW'(PMIN)) && (run <= RW'(PMAX));
  assign word  = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= FR_GAPW;
      run <= '0;
      cnt <= '0;
      val <= 1'b0;
      sr  <= '0;
      eos <= 1'b0;
    end else begin
      eos <= 1'b0;
      if (tick) begin
        unique case (st)
          FR_GAPW: begin
            if (!nul) run <= '0;
            else if (run >= RW'(GAP - 1)) begin
              st  <= FR_IDLE;
              run <= '0;
            end else run <= run + 1'b1;
          end
          FR_IDLE: begin
            cnt <= '0;
            if (bad) begin
              st  <= FR_GAPW;
              run <= '0;
            end else if (!nul) begin
              st  <= FR_MARK;
              val <= line_one;
              run <= RW'(1);
            end
          end
          FR_MARK: begin
            if (bad || (!nul && (line_one != val))) begin
              st  <= FR_GAPW;
              run <= '0;
            end else if (!nul) begin
              if (run != RMAX) run <= run + 1'b1;
            end else if (in_ph) begin
              sr  <= {val, sr[WB-1:1]};
              run <= RW'(1);
              if (cnt == CW'(WB - 1)) begin
                eos <= 1'b1;
                cnt <= '0;
                st  <= FR_GAPW;
              end else begin
                cnt <= cnt + 1'b1;
                st  <= FR_SPACE;
              end
            end else begin
              st  <= FR_GAPW;
              run <= RW'(1);
            end
          end
          FR_SPACE: begin
            if (bad) begin
              st  <= FR_GAPW;
              run <= '0;
            end else if (nul) begin
              if (run >= RW'(GAP - 1)) begin
                st  <= FR_IDLE;
                run <= '0;
                cnt <= '0;
              end else run <= run + 1'b1;
            end else if (in_ph) begin
              st  <= FR_MARK;
              val <= line_one;
              run <= RW'(1);
            end else begin
              st  <= FR_GAPW;
              run <= '0;
            end
          end
          default: st <= FR_GAPW;
        endcase
      end
    end
  end
endmodule

// File: rtl/avw_store.sv
module avw_store #(
  parameter int WB = 32,
  parameter int FB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eos,
  input  logic [WB-1:0]   word,
  input  logic            filt_en,
  input  logic [1:0]      filt_bits,
  input  logic            rd_en,
  input  logic            rd_hi,
  output logic [WB/2-1:0] rd_data,
  output logic            ready_n
);
  localparam int HW = WB / 2;

  logic [WB-1:0] lat;
  logic          rdy;
  logic [1:0]    got, got_n;
  logic          accept;

  assign accept  = eos && (!filt_en || (word[FB+1:FB] == filt_bits));
  assign rd_data = rd_hi ? lat[WB-1:HW] : lat[HW-1:0];
  assign ready_n = !rdy;

  always_comb begin
    got_n = got | (rd_hi ? 2'b10 : 2'b01);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0;
      rdy <= 1'b0;
      got <= 2'b00;
    end else if (accept) begin
      lat <= {~^word, word[WB-2:0]};
      rdy <= 1'b1;
      got <= 2'b00;
    end else if (rd_en && rdy) begin
      if (&got_n) begin
        rdy <= 1'b0;
        got <= 2'b00;
      end else begin
        got <= got_n;
      end
    end
  end
endmodule

// File: rtl/avio_word_rx.sv
module avio_word_rx #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  parameter int OSR      = 10,
  parameter int WB       = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_rate,
  input  logic            filt_en,
  input  logic [1:0]      filt_bits,
  input  logic            line_one,
  input  logic            line_zero,
  input  logic            rd_en,
  input  logic            rd_hi,
  output logic [WB/2-1:0] rd_data,
  output logic            ready_n
);
  logic          tick;
  logic          eos;
  logic [WB-1:0] sh_word;

  avw_tick #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk(clk), .rst_n(rst_n), .slow(slow_rate), .tick(tick)
  );

  avw_framer #(.OSR(OSR), .WB(WB)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .line_one(line_one), .line_zero(line_zero),
    .eos(eos), .word(sh_word)
  );

  avw_store #(.WB(WB), .FB(8)) u_store (
    .clk(clk), .rst_n(rst_n), .eos(eos), .word(sh_word),
    .filt_en(filt_en), .filt_bits(filt_bits),
    .rd_en(rd_en), .rd_hi(rd_hi),
    .rd_data(rd_data), .ready_n(ready_n)
  );
endmodule

// File: rtl/avw_rx_chk.sv
module avw_rx_chk #(
  parameter int WB = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            eos,
  input logic [WB-1:0]   word,
  input logic            filt_en,
  input logic [1:0]      filt_bits,
  input logic            rd_en,
  input logic            rd_hi,
  input logic [WB/2-1:0] rd_data,
  input logic            ready_n
);
  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(eos));

  // R6
  release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> $past(rd_en));

  // R4
  filt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && filt_en && (word[9:8] != filt_bits) && ready_n) |=> ready_n);

  // R5
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ready_n) && rd_hi) |-> (rd_data[WB/2-1] == ~^$past(word)));
endmodule

bind avio_word_rx avw_rx_chk #(.WB(WB)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .eos(eos), .word(sh_word),
  .filt_en(filt_en), .filt_bits(filt_bits), .rd_en(rd_en), .rd_hi(rd_hi),
  .rd_data(rd_data), .ready_n(ready_n)
);

// File: tb/test_avio_word_rx.sv
module test_avio_word_rx;
  localparam int DF = 2;
  localparam int DS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_rate = 1'b0, filt_en = 1'b0;
  logic [1:0]  filt_bits = 2'b00;
  logic        line_one = 1'b0, line_zero = 1'b0;
  logic        rd_en = 1'b0, rd_hi = 1'b0;
  logic [15:0] rd_data;
  logic        ready_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  avio_word_rx #(.DIV_FAST(DF), .DIV_SLOW(DS)) i_avio_word_rx (
    .clk(clk), .rst_n(rst_n), .slow_rate(slow_rate), .filt_en(filt_en),
    .filt_bits(filt_bits), .line_one(line_one), .line_zero(line_zero),
    .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data), .ready_n(ready_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expw(input logic [31:0] w);
    return {~^w, w[30:0]};
  endfunction

  task automatic phase(input logic o, input logic z, input int nclk);
    line_one  = o;
    line_zero = z;
    repeat (nclk) @(negedge clk);
  endtask

  // bad_bit: both rails high in that bit; short_bit: 2-sample data phase
  task automatic send(input logic [31:0] w, input int div, input int bad_bit, input int short_bit);
    for (int b = 0; b < 32; b++) begin
      if (b == bad_bit) phase(1'b1, 1'b1, 5 * div);
      else phase(w[b], ~w[b], ((b == short_bit) ? 2 : 5) * div);
      phase(1'b0, 1'b0, 5 * div);
    end
    phase(1'b0, 1'b0, 40 * div);
  endtask

  task automatic rd_half(input logic h, output logic [15:0] d);
    rd_hi = h;
    rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_word(input logic hi_first, output logic [31:0] w);
    logic [15:0] a, b;
    rd_half(hi_first, a);
    rd_half(~hi_first, b);
    w = hi_first ? {a, b} : {b, a};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    logic [31:0] w, got;
    logic [15:0] h;
    repeat (5) @(negedge clk);
    check("R9 reset ready_n", {31'd0, ready_n}, 32'd1);
    rst_n = 1'b1;
    phase(1'b0, 1'b0, 200);

    // R2 R3 R5 R6: sweep patterns at fast rate, alternating read order
    for (int i = 0; i < 24; i++) begin
      if (i == 0) w = 32'h0;
      else if (i == 1) w = 32'hFFFF_FFFF;
      else if (i == 2) w = 32'hAAAA_AAAA;
      else if (i == 3) w = 32'h5555_5555;
      else if (i < 12) w = 32'h1 << (4 * (i - 4) + 1);
      else w = i * 32'h9E37_79B9;
      send(w, DF, -1, -1);
      check("R3 accepted", {31'd0, ready_n}, 32'd0);
      rd_word(i[0], got);
      check("R2 R5 word", got, expw(w));
      check("R6 released", {31'd0, ready_n}, 32'd1);
    end

    // R1 slow rate
    slow_rate = 1'b1;
    phase(1'b0, 1'b0, 200);
    for (int i = 0; i < 3; i++) begin
      w = 32'hC3A5_0F1E ^ (i * 32'h0101_0101);
      send(w, DS, -1, -1);
      rd_word(1'b0, got);
      check("R1 slow word", got, expw(w));
    end
    // R1 fast word in slow mode
    send(32'h1357_9BDF, DF, -1, -1);
    phase(1'b0, 1'b0, 200);
    check("R1 fast in slow rejected", {31'd0, ready_n}, 32'd1);
    // R1 slow word in fast mode
    slow_rate = 1'b0;
    send(32'h1357_9BDF, DS, -1, -1);
    check("R1 slow in fast rejected", {31'd0, ready_n}, 32'd1);
    send(32'h2468_ACE0, DF, -1, -1);
    rd_word(1'b1, got);
    check("R1 recover", got, expw(32'h2468_ACE0));

    // R4 filter sweep
    filt_en = 1'b1;
    filt_bits = 2'b10;
    for (int c = 0; c < 4; c++) begin
      w = (32'h1234_5678 & ~32'h300) | (32'(c) << 8);
      send(w, DF, -1, -1);
      check("R4 filter ready_n", {31'd0, ready_n}, (c == 2) ? 32'd0 : 32'd1);
      if (c == 2) begin
        rd_word(1'b0, got);
        check("R4 filter word", got, expw(w));
      end
    end
    filt_en = 1'b0;

    // R6 same half twice, spurious read
    rd_half(1'b0, h);
    check("R6 read while idle", {31'd0, ready_n}, 32'd1);
    send(32'h8001_7FFE, DF, -1, -1);
    rd_half(1'b0, h);
    rd_half(1'b0, h);
    check("R6 same half twice", {31'd0, ready_n}, 32'd0);
    rd_half(1'b1, h);
    check("R6 both halves", {31'd0, ready_n}, 32'd1);

    // R7 overwrite
    send(32'h0F0F_0F0F, DF, -1, -1);
    rd_half(1'b0, h);
    send(32'h7654_3210, DF, -1, -1);
    rd_half(1'b1, h);
    check("R7 still ready", {31'd0, ready_n}, 32'd0);
    rd_word(1'b0, got);
    check("R7 overwritten", got, expw(32'h7654_3210));
    check("R7 released", {31'd0, ready_n}, 32'd1);

    // R8 both rails high
    send(32'h9999_6666, DF, 11, -1);
    check("R8 aborted", {31'd0, ready_n}, 32'd1);
    send(32'h9999_6667, DF, -1, -1);
    rd_word(1'b0, got);
    check("R8 recover", got, expw(32'h9999_6667));

    // R10 short data phase
    send(32'h4242_2424, DF, -1, 4);
    check("R10 aborted", {31'd0, ready_n}, 32'd1);
    send(32'h4242_2425, DF, -1, -1);
    rd_word(1'b1, got);
    check("R10 recover", got, expw(32'h4242_2425));

    // R9 reset with word pending and mid-word
    send(32'hDEAD_BEEF, DF, -1, -1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears ready", {31'd0, ready_n}, 32'd1);
    rst_n = 1'b1;
    phase(1'b0, 1'b0, 200);
    fork
      send(32'hFACE_CAFE, DF, -1, -1);
      begin
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
      end
    join
    check("R9 mid-word dropped", {31'd0, ready_n}, 32'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule